// File: doc/BRIEF.md
# Indirect Directory RAM Access Engine

This block gives software a path into a two-way directory memory without going through the normal lookup traffic. Software uses two registers. The content register holds a full memory word: a data part and its check bits. The trigger register holds a command, a way select and an entry index. Writing the trigger register starts the command. Reading either register has no side effect.

Four commands exist. A raw read copies a stored word, check bits included and uncorrected, into the content register. A raw write stores the content register unchanged. A generated write stores the data part and replaces the check bits with a freshly computed code. An XOR read-modify-write reads an entry, XORs it with the content register and writes the result back in one uninterrupted sequence. The content register is left as it was, so the same error pattern can be injected into many entries one after another.

While a command runs, a busy flag is high and register writes are dropped. A one-cycle done pulse marks the end of every command. The memories are single-ported and have one cycle of read latency. Only the selected way sees an enable.

Top module: `dir_ram_indirect`

## Requirements
- R1: After reset, busy, done, ram_en and ram_we are 0, and both registers read as 0.
- R2: Trigger register (reg_sel=1) field layout: bits 1:0 hold the command, bit 2 holds the way, and bits 14:3 hold the index. An idle write stores bits 14:0. A read returns those bits, with bits 63:15 always reading 0.
- R3: Content register (reg_sel=0) field layout: bits 31:0 hold the data and bits 38:32 hold the check bits. An idle write stores bits 38:0. A read returns them, with bits 63:39 reading 0.
- R4: Command 2'b11 (raw read) asserts the way enable without a write strobe in the first cycle after the trigger. The stored word, check bits included and uncorrected, appears in the content register in the done cycle, which is the third cycle after the trigger.
- R5: Command 2'b10 (raw write) writes the content register unchanged in the first cycle after the trigger: data on ram_wdata and check bits on ram_wchk.
- R6: Command 2'b01 (generated write) writes the content data together with a generated check code. The code is built as follows:
  - Data bit k takes the (k+1)-th position among codeword positions 1..38 that is not a power of two.
  - Check bit i (for i from 0 to 5) is the XOR of all data bits whose position has bit i set.
  - Check bit 6 is the XOR of all 32 data bits and check bits 0 to 5.
- R7: Command 2'b00 runs as follows:
  - It reads in cycle 1 after the trigger, merges in cycle 2, and writes the stored word XOR content to the same entry in cycle 3.
  - The done pulse follows in cycle 4.
  - The content register is not changed by this command.
- R8: Way 0 drives ram_en/ram_we bit 0 and way 1 drives bit 1. The other way is never enabled. ram_addr equals the index field with no hashing.
- R9: busy is high from the cycle after an accepted trigger until the cycle before done. Trigger and content writes made while busy are ignored.
- R10: done is high for exactly one cycle, after the last memory access. A trigger written in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 1 selects the trigger register, 0 selects the content register |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Selected register value |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| ram_en | output | 2 | Per-way memory enable |
| ram_we | output | 2 | Per-way write strobe |
| ram_addr | output | IW | Entry address |
| ram_wdata | output | DW | Write data lane |
| ram_wchk | output | CW | Write check-bit lane |
| ram0_rdata | input | DW | Way 0 read data |
| ram0_rchk | input | CW | Way 0 read check bits |
| ram1_rdata | input | DW | Way 1 read data |
| ram1_rchk | input | CW | Way 1 read check bits |

## Verification
The bench builds the block with its defaults: 32 data bits, 7 check bits and a 12-bit index. These widths make the full trigger layout reachable, so index 4095 and a write of all ones into the trigger register both exercise the top of the index field and the zeroed upper bits. The bench's memories are preloaded with a pattern that depends on the way. A raw read from either way therefore tells the ways apart and exposes any leakage between them. Repeated XOR writes with one content value, commands issued while busy, and a trigger placed in a done cycle cover the sequencing corners.

// File: rtl/dir_ram_indirect.sv
module dir_ram_indirect #(
  parameter int DW = 32,
  parameter int CW = 7,
  parameter int IW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_sel,
  input  logic [63:0]   reg_wdata,
  output logic [63:0]   reg_rdata,
  output logic          busy,
  output logic          done,
  output logic [1:0]    ram_en,
  output logic [1:0]    ram_we,
  output logic [IW-1:0] ram_addr,
  output logic [DW-1:0] ram_wdata,
  output logic [CW-1:0] ram_wchk,
  input  logic [DW-1:0] ram0_rdata,
  input  logic [CW-1:0] ram0_rchk,
  input  logic [DW-1:0] ram1_rdata,
  input  logic [CW-1:0] ram1_rchk
);
  localparam int EW = DW + CW;
  localparam int TW = IW + 3;
  localparam logic [1:0] OP_RMW = 2'b00, OP_WGEN = 2'b01, OP_WRAW = 2'b10, OP_RRAW = 2'b11;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_CAP, S_WR} st_t;

  st_t st;
  logic [TW-1:0] trig;
  logic [EW-1:0] content, hold, rword, wword;

  function automatic logic [CW-1:0] gen_chk(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    int k;
    c = '0;
    k = 0;
    for (int p = 1; p < EW; p++) begin
      if ((p & (p - 1)) != 0 && k < DW) begin
        for (int i = 0; i < CW - 1; i++)
          if (p[i]) c[i] = c[i] ^ d[k];
        k++;
      end
    end
    c[CW-1] = ^{d, c[CW-2:0]};
    return c;
  endfunction

  wire [1:0] cmd     = trig[1:0];
  wire [1:0] way_sel = trig[2] ? 2'b10 : 2'b01;
  wire       trig_go = reg_wr & reg_sel & ~busy;
  wire       cont_go = reg_wr & ~reg_sel & ~busy;

  assign busy      = (st != S_IDLE);
  assign rword     = trig[2] ? {ram1_rchk, ram1_rdata} : {ram0_rchk, ram0_rdata};
  assign ram_en    = (st == S_RD || st == S_WR) ? way_sel : 2'b00;
  assign ram_we    = (st == S_WR) ? way_sel : 2'b00;
  assign ram_addr  = trig[TW-1:3];
  assign {ram_wchk, ram_wdata} = wword;
  assign reg_rdata = reg_sel ? 64'(trig) : 64'(content);

  always_comb begin
    case (cmd)
      OP_WRAW: wword = content;
      OP_WGEN: wword = {gen_chk(content[DW-1:0]), content[DW-1:0]};
      default: wword = hold;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      trig    <= '0;
      content <= '0;
      hold    <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (trig_go) begin
        trig <= reg_wdata[TW-1:0];
        st   <= (reg_wdata[1:0] == OP_RRAW || reg_wdata[1:0] == OP_RMW) ? S_RD : S_WR;
      end
      if (cont_go) content <= reg_wdata[EW-1:0];
      case (st)
        S_RD: st <= S_CAP;
        S_CAP: begin
          if (cmd == OP_RRAW) begin
            content <= rword;
            st      <= S_IDLE;
            done    <= 1'b1;
          end else begin
            hold <= rword ^ content;
            st   <= S_WR;
          end
        end
        S_WR: begin
          st   <= S_IDLE;
          done <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assert_one_way_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ram_en));
  assert_we_needs_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we & ~ram_en) == 2'b00);
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_busy_from_trigger_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_sel));
  assert_rmw_same_way_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we != 2'b00 && cmd == OP_RMW) |-> ($past(ram_en, 2) == ram_en && $past(ram_we, 2) == 2'b00));
  assert_content_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cmd != OP_RRAW) |=> $stable(content));
endmodule

// File: tb/dir_ram_indirect_bench.sv
module dir_ram_indirect_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4096;

  typedef struct {
    bit [1:0] en; bit [1:0] we; int addr; bit [31:0] wd; bit [6:0] wc;
    bit busy; bit done; bit setc; bit [38:0] c; string tag;
  } rec_t;

  logic clk = 0, rst_n = 0;
  logic in_wr = 0, in_sel = 0;
  logic [63:0] in_wdata = '0;
  logic [63:0] reg_rdata;
  logic busy, done;
  logic [1:0] ram_en, ram_we;
  logic [11:0] ram_addr;
  logic [31:0] ram_wdata, r0d, r1d;
  logic [6:0] ram_wchk, r0c, r1c;

  bit [38:0] mem0 [DEPTH], mem1 [DEPTH], ref0 [DEPTH], ref1 [DEPTH];
  bit [38:0] m_content;
  bit [14:0] m_trig;
  rec_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dir_ram_indirect u_dir_ram_indirect (
    .clk(clk), .rst_n(rst_n), .reg_wr(in_wr), .reg_sel(in_sel), .reg_wdata(in_wdata),
    .reg_rdata(reg_rdata), .busy(busy), .done(done), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_wchk(ram_wchk),
    .ram0_rdata(r0d), .ram0_rchk(r0c), .ram1_rdata(r1d), .ram1_rchk(r1c));

  always @(posedge clk) begin
    if (ram_en[0]) begin
      if (ram_we[0]) mem0[ram_addr] <= {ram_wchk, ram_wdata};
      else {r0c, r0d} <= mem0[ram_addr];
    end
    if (ram_en[1]) begin
      if (ram_we[1]) mem1[ram_addr] <= {ram_wchk, ram_wdata};
      else {r1c, r1d} <= mem1[ram_addr];
    end
  end

  function automatic bit [6:0] ref_chk(bit [31:0] d);
    bit [6:0] c = '0;
    int pos = 0;
    for (int k = 0; k < 32; k++) begin
      pos++;
      while ($countones(pos) == 1) pos++;
      for (int i = 0; i < 6; i++) if ((pos >> i) & 1) c[i] ^= d[k];
    end
    c[6] = (^d) ^ (^c[5:0]);
    return c;
  endfunction

  function automatic rec_t idle_rec();
    rec_t r;
    r.en = 0; r.we = 0; r.addr = 0; r.wd = 0; r.wc = 0;
    r.busy = 0; r.done = 0; r.setc = 0; r.c = 0; r.tag = "";
    return r;
  endfunction

  task automatic cmp(string tag, logic [63:0] act, logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic sched(bit [1:0] cmd, bit w, int idx);
    rec_t r;
    bit [38:0] old, nw;
    bit [1:0] e;
    old = w ? ref1[idx] : ref0[idx];
    e = w ? 2'b10 : 2'b01;
    if (cmd == 2'b11 || cmd == 2'b00) begin
      r = idle_rec(); r.busy = 1; r.en = e; r.addr = idx; q.push_back(r);
      r = idle_rec(); r.busy = 1; q.push_back(r);
    end
    if (cmd == 2'b11) begin
      r = idle_rec(); r.done = 1; r.setc = 1; r.c = old; q.push_back(r);
    end else begin
      if (cmd == 2'b10) nw = m_content;
      else if (cmd == 2'b01) nw = {ref_chk(m_content[31:0]), m_content[31:0]};
      else nw = old ^ m_content;
      r = idle_rec(); r.busy = 1; r.en = e; r.we = e; r.addr = idx;
      r.wd = nw[31:0]; r.wc = nw[38:32];
      r.tag = (cmd == 2'b10) ? "R5" : (cmd == 2'b01) ? "R6" : "R7";
      q.push_back(r);
      r = idle_rec(); r.done = 1; q.push_back(r);
      if (w) ref1[idx] = nw; else ref0[idx] = nw;
    end
  endtask

  task automatic tick();
    rec_t cur;
    cur = (q.size() > 0) ? q[0] : idle_rec();
    if (q.size() > 0) void'(q.pop_front());
    if (in_wr && !cur.busy) begin
      if (in_sel) begin
        m_trig = in_wdata[14:0];
        sched(in_wdata[1:0], in_wdata[2], int'(in_wdata[14:3]));
      end else m_content = in_wdata[38:0];
    end
    @(posedge clk);
    @(negedge clk);
    cur = (q.size() > 0) ? q[0] : idle_rec();
    if (cur.setc) m_content = cur.c;
    cmp("R9 busy", busy, cur.busy);
    cmp("R10 done", done, cur.done);
    cmp("R8 ram_en", ram_en, cur.en);
    cmp("R8 ram_we", ram_we, cur.we);
    if (cur.en != 0) cmp("R8 ram_addr", ram_addr, cur.addr);
    if (cur.we != 0) begin
      cmp({cur.tag, " ram_wdata"}, ram_wdata, cur.wd);
      cmp({cur.tag, " ram_wchk"}, ram_wchk, cur.wc);
    end
    if (in_sel) cmp("R2 trigger readback", reg_rdata, {49'b0, m_trig});
    else cmp("R3 content readback", reg_rdata, {25'b0, m_content});
  endtask

  task automatic wr_reg(bit sel, logic [63:0] d);
    in_wr = 1; in_sel = sel; in_wdata = d;
    tick();
    in_wr = 0;
  endtask

  function automatic logic [63:0] trg(bit [1:0] cmd, bit w, int idx);
    return 64'((idx << 3) | (int'(w) << 2) | int'(cmd));
  endfunction

  task automatic run(bit [1:0] cmd, bit w, int idx);
    wr_reg(1, trg(cmd, w, idx));
    in_sel = 0;
    repeat ((cmd == 2'b11) ? 2 : (cmd == 2'b00) ? 3 : 1) tick();
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem0[i] = {7'(i * 3), 32'(i * 32'h9E37_79B1)};
      mem1[i] = {7'(i * 5 + 1), 32'(i * 32'h85EB_CA6B) ^ 32'hA5A5_0000};
      ref0[i] = mem0[i];
      ref1[i] = mem1[i];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    cmp("R1 busy", busy, 0);
    cmp("R1 done", done, 0);
    cmp("R1 ram_en", ram_en, 0);
    cmp("R1 ram_we", ram_we, 0);
    cmp("R1 content", reg_rdata, 0);
    in_sel = 1; #1;
    cmp("R1 trigger", reg_rdata, 0);
    rst_n = 1;
    tick();

    wr_reg(1, 64'hFFFF_FFFF_FFFF_FFFF);
    cmp("R2 upper bits zero", reg_rdata, 64'h7FFF);
    in_sel = 0;
    repeat (2) tick();
    cmp("R4 raw read way1 top index", reg_rdata, {25'b0, ref1[4095]});

    wr_reg(0, 64'hFFFF_FF55_DEAD_BEEF);
    cmp("R3 content masked", reg_rdata, 64'h55_DEAD_BEEF);
    run(2'b10, 0, 0);
    run(2'b10, 1, 4095);
    wr_reg(0, 64'h0000_0000_0000_0001);
    run(2'b01, 0, 5);
    run(2'b11, 0, 5);
    cmp("R6 generated word", reg_rdata, {25'b0, ref_chk(32'h1), 32'h1});

    wr_reg(0, 64'h40_0000_0001);
    wr_reg(1, trg(2'b00, 0, 5));
    in_sel = 0;
    wr_reg(0, 64'h12_3456_789A);
    wr_reg(1, trg(2'b10, 1, 9));
    in_sel = 0;
    tick();
    cmp("R9 content write ignored", reg_rdata, 64'h40_0000_0001);
    run(2'b00, 1, 7);
    cmp("R7 content unchanged", reg_rdata, 64'h40_0000_0001);
    run(2'b11, 0, 5);
    cmp("R7 xor result", reg_rdata, {25'b0, ref_chk(32'h1) ^ 7'h40, 32'h0});
    run(2'b11, 1, 7);
    cmp("R7 second entry", reg_rdata, {25'b0, ref1[7]});
    run(2'b11, 1, 9);
    cmp("R9 trigger write ignored", reg_rdata, {25'b0, ref1[9]});
    run(2'b11, 0, 0);
    cmp("R5 raw write stored", reg_rdata, 64'h55_DEAD_BEEF);
    in_sel = 1; tick();
    cmp("R2 trigger holds fields", reg_rdata, trg(2'b11, 0, 0));
    in_sel = 0;
    run(2'b11, 1, 4095);
    cmp("R8 way1 written directly", reg_rdata, 64'h55_DEAD_BEEF);
    run(2'b10, 1, 100);
    run(2'b11, 1, 100);
    cmp("R10 back-to-back accepted", reg_rdata, 64'h55_DEAD_BEEF);
    repeat (3) tick();

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule